// File: doc/BRIEF.md
# External Edge Interrupt Line Controller

This block watches a bank of external input lines and turns selected signal edges into latched interrupt requests for a downstream priority controller. Each line k can take pin k of any one of several ports, picked by a per-line source selector. The chosen pin goes through a two-flop synchroniser and a one-cycle edge detector. Each line has independent enables for the rising edge and the falling edge. A qualifying edge on a line that is enabled in interrupt mode sets that line's pending flag. The flag stays set until software clears it.

Software reaches the block through a small word-wide register port. A write takes effect on the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`. The pending flags that are also enabled are merged into three level-sensitive request outputs, one for each group of lines. The controller sees a request as long as any enabled pending flag in the group remains.

Top module: `xline_irq_ctrl`

## Requirements
- R1: After synchronous active-low reset, every register reads zero and `irq_grp` is 3'b000. This covers line enable, rising select, falling select, source select and pending.
- R2: Register map (3-bit address): 0 = line enable, 1 = rising-edge select, 2 = falling-edge select, 3 = pending/status, 4 = source select. For registers 0 to 3, bit k belongs to line k. When line k is enabled and its rising select is set, a 0-to-1 change on its source pin sets pending bit k. A line with neither edge selected never becomes pending.
- R3: The falling-edge select is independent of the rising-edge select. With falling selected, a 1-to-0 change sets pending. With both selected, either change sets pending. An edge of a kind that is not selected sets nothing.
- R4: A line whose enable bit is 0 never latches a pending flag. Enabling the line afterwards, with no new edge, still reads 0 for that line.
- R5: A pending bit stays set through any later pin activity until software writes 1 to its bit at address 3. Writing 0 to a bit there changes nothing.
- R6: If a clear of bit k and a new qualifying edge on line k land in the same clock cycle, bit k ends up set.
- R7: Reading address 3 returns the pending flags ANDed with the line enables. Clearing the enable of a pending line hides the bit and drops its group request. Re-enabling the line shows the bit again.
- R8: Line k takes pin k of the port given by bits [2k+1:2k] of address 4. Port p pin k is `port_pins[p*16+k]`. Pins of other ports have no effect on line k.
- R9: `irq_grp[0]` is the OR of the enabled pending bits of lines 0–1. `irq_grp[1]` covers lines 2–3 and `irq_grp[2]` covers lines 4–15. Each output stays high as long as any such bit remains.
- R10: A pin change that settles before rising clock edge 1 shows as pending after rising edge 3, and not after rising edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_pins | input | 64 | Raw pins; port p pin k at bit p*16+k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_grp | output | 3 | Grouped level interrupt requests |

## Verification
The bench targets several corner cases.

- A clear that coincides with a fresh edge: a design that lets the clear win loses the interrupt.
- An edge arriving while the line is disabled: a design that latches it anyway raises a stale request once the line is enabled.
- Activity on a port the line is not routed to: a mux indexed with the wrong stride would pick it up.
- Edge timing is checked one cycle before and one cycle after the pending flag should appear. A missing or extra synchroniser stage is caught there.
- Group requests are checked with lines in two different groups pending at once. This catches a wrong group boundary.

// File: rtl/xline_pkg.sv
// Shared constants for the edge interrupt line controller: register
// addresses and the group boundary functions. Assumes three request groups.
package xline_pkg;

    localparam logic [2:0] ADDR_EN   = 3'd0;
    localparam logic [2:0] ADDR_RISE = 3'd1;
    localparam logic [2:0] ADDR_FALL = 3'd2;
    localparam logic [2:0] ADDR_PEND = 3'd3;
    localparam logic [2:0] ADDR_SRC  = 3'd4;

    localparam int NUM_GRP = 3;

    // Lowest line number belonging to group g.
    function automatic int grp_lo(input int g, input int last0, input int last1);
        case (g)
            0:       return 0;
            1:       return last0 + 1;
            default: return last1 + 1;
        endcase
    endfunction

    // Highest line number belonging to group g.
    function automatic int grp_hi(input int g, input int last0, input int last1,
                                  input int nlines);
        case (g)
            0:       return last0;
            1:       return last1;
            default: return nlines - 1;
        endcase
    endfunction

endpackage

// File: rtl/xline_regs.sv
// Register file: holds the line enables, the edge selects and the packed
// source selects. Decodes write-one-to-clear strobes for the pending flags
// and muxes read data. Assumes NUM_LINES*SRC_W <= DATA_W.
module xline_regs #(
    parameter int NUM_LINES = 16,
    parameter int SRC_W     = 2,
    parameter int DATA_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [2:0]                 reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    input  logic [NUM_LINES-1:0]       status,
    output logic [NUM_LINES-1:0]       line_en,
    output logic [NUM_LINES-1:0]       rise_sel,
    output logic [NUM_LINES-1:0]       fall_sel,
    output logic [NUM_LINES*SRC_W-1:0] src_sel,
    output logic [NUM_LINES-1:0]       clr_mask,
    output logic [DATA_W-1:0]          reg_rdata
);
    import xline_pkg::*;

    localparam int SEL_BITS = NUM_LINES * SRC_W;

    // Configuration register updates on write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_en  <= '0;
            rise_sel <= '0;
            fall_sel <= '0;
            src_sel  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_EN:   line_en  <= reg_wdata[NUM_LINES-1:0];
                ADDR_RISE: rise_sel <= reg_wdata[NUM_LINES-1:0];
                ADDR_FALL: fall_sel <= reg_wdata[NUM_LINES-1:0];
                ADDR_SRC:  src_sel  <= reg_wdata[SEL_BITS-1:0];
                default: ;
            endcase
        end
    end

    // Write-one-to-clear strobes toward the pending flags.
    always_comb begin
        clr_mask = '0;
        if (reg_wr && reg_addr == ADDR_PEND)
            clr_mask = reg_wdata[NUM_LINES-1:0];
    end

    // Combinational read data selection.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_EN:   reg_rdata[NUM_LINES-1:0] = line_en;
            ADDR_RISE: reg_rdata[NUM_LINES-1:0] = rise_sel;
            ADDR_FALL: reg_rdata[NUM_LINES-1:0] = fall_sel;
            ADDR_PEND: reg_rdata[NUM_LINES-1:0] = status;
            ADDR_SRC:  reg_rdata[SEL_BITS-1:0]  = src_sel;
            default: ;
        endcase
    end

endmodule

// File: rtl/xline_src_mux.sv
// Per-line source multiplexer: line k takes pin k of the selected port.
// Select codes beyond NUM_PORTS-1 yield a constant 0.
module xline_src_mux #(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 4,
    parameter int SRC_W     = 2
) (
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
    input  logic [NUM_LINES*SRC_W-1:0]     src_sel,
    output logic [NUM_LINES-1:0]           line_raw
);
    localparam int CAND = 1 << SRC_W;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        logic [CAND-1:0]  cand;
        logic [SRC_W-1:0] sel;
        // Gather pin k of every port, padding unused codes.
        for (genvar p = 0; p < CAND; p++) begin : g_port
            if (p < NUM_PORTS) begin : g_real
                assign cand[p] = port_pins[p*NUM_LINES + k];
            end else begin : g_pad
                assign cand[p] = 1'b0;
            end
        end
        assign sel = src_sel[k*SRC_W +: SRC_W];
        // Pick the routed pin for this line.
        assign line_raw[k] = cand[sel];
    end

endmodule

// File: rtl/xline_sync_edge.sv
// Two-flop synchroniser plus a history flop per line. Emits one-cycle
// rise and fall pulses. Assumes inputs may be asynchronous to clk.
module xline_sync_edge #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_raw,
    output logic [NUM_LINES-1:0] rise,
    output logic [NUM_LINES-1:0] fall
);
    logic [NUM_LINES-1:0] meta_q;
    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] prev_q;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        // Synchroniser stages and history for line k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[k] <= 1'b0;
                sync_q[k] <= 1'b0;
                prev_q[k] <= 1'b0;
            end else begin
                meta_q[k] <= line_raw[k];
                sync_q[k] <= meta_q[k];
                prev_q[k] <= sync_q[k];
            end
        end
        // Edge pulses from the current and previous synchronised values.
        assign rise[k] =  sync_q[k] & ~prev_q[k];
        assign fall[k] = ~sync_q[k] &  prev_q[k];
    end

    // R10: a rise pulse lasts a single cycle per transition.
    assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & $past(rise)) == '0));
    // R10: a fall pulse lasts a single cycle per transition.
    assert_fall_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall & $past(fall)) == '0));

endmodule

// File: rtl/xline_pend.sv
// Sticky pending flags: set by qualifying edges on enabled lines, cleared
// by write-one strobes. A set in the same cycle as a clear wins.
module xline_pend #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_en,
    input  logic [NUM_LINES-1:0] rise_sel,
    input  logic [NUM_LINES-1:0] fall_sel,
    input  logic [NUM_LINES-1:0] rise,
    input  logic [NUM_LINES-1:0] fall,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] pend
);
    logic [NUM_LINES-1:0] set_mask;

    // Qualify edges with per-line selects and enables.
    always_comb begin
        set_mask = line_en & ((rise_sel & rise) | (fall_sel & fall));
    end

    // Pending flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | set_mask;
    end

    // R5: a flag not cleared stays set.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(pend) & ~$past(clr_mask)) & ~pend) == '0));
    // R5: a clear with no competing edge empties the flag.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & $past(clr_mask) & ~$past(set_mask)) == '0));
    // R6: a qualifying edge always leaves its flag set.
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_mask) & ~pend) == '0));
    // R4: a newly set flag needs the line enabled the cycle before.
    assert_no_set_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend & ~$past(pend)) & ~$past(line_en)) == '0));

endmodule

// File: rtl/xline_irq_ctrl.sv
// Top of the edge interrupt line controller. Routes pins to lines, detects
// edges, latches pending flags and merges enabled flags into three grouped
// level requests. Group g covers lines grp_lo..grp_hi. Assumes
// 0 <= GRP0_LAST < GRP1_LAST < NUM_LINES-1.
module xline_irq_ctrl #(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 32,
    parameter int GRP0_LAST = 1,
    parameter int GRP1_LAST = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
    input  logic                           reg_wr,
    input  logic [2:0]                     reg_addr,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic [xline_pkg::NUM_GRP-1:0]  irq_grp
);
    import xline_pkg::*;

    localparam int SRC_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [NUM_LINES-1:0]       line_en, rise_sel, fall_sel, clr_mask;
    logic [NUM_LINES*SRC_W-1:0] src_sel;
    logic [NUM_LINES-1:0]       line_raw, rise, fall, pend, status;

    xline_regs #(.NUM_LINES(NUM_LINES), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status(status), .line_en(line_en),
        .rise_sel(rise_sel), .fall_sel(fall_sel), .src_sel(src_sel),
        .clr_mask(clr_mask), .reg_rdata(reg_rdata)
    );

    xline_src_mux #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SRC_W(SRC_W)) u_mux (
        .port_pins(port_pins), .src_sel(src_sel), .line_raw(line_raw)
    );

    xline_sync_edge #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_raw(line_raw), .rise(rise), .fall(fall)
    );

    xline_pend #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .rise_sel(rise_sel),
        .fall_sel(fall_sel), .rise(rise), .fall(fall), .clr_mask(clr_mask),
        .pend(pend)
    );

    // Status visible to software and to the group merge.
    assign status = pend & line_en;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = grp_lo(g, GRP0_LAST, GRP1_LAST);
        localparam int HI = grp_hi(g, GRP0_LAST, GRP1_LAST, NUM_LINES);
        // Level request for this group.
        assign irq_grp[g] = |status[HI:LO];
    end

    // R4: with every line disabled no request is raised.
    assert_quiet_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en == '0) |-> (irq_grp == '0));
    // R1: requests are low on the first cycle out of reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_grp == '0));

endmodule

// File: tb/xline_irq_ctrl_bench.sv
// Bench for the edge interrupt line controller: a vector table loop, then
// directed tests for reset, timing and corner cases.
module xline_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pins = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq_grp;

    int tests = 0;
    int fails = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    xline_irq_ctrl u_xline_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .port_pins(pins), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_grp(irq_grp)
    );

    // Vector fields: [10:7] line, [6:5] port, [4] rise, [3] fall,
    // [2] pin goes up, [1] toggle another port's pin instead, [0] expected.
    localparam logic [10:0] VEC [8] = '{
        {4'd0,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd2,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd3,  2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'd9,  2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'd15, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd5,  2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd1,  2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setpin(input int idx, input logic v);
        @(negedge clk);
        pins[idx] = v;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [2:0] grp_bit(input int line);
        if (line < 2)      return 3'b001;
        else if (line < 4) return 3'b010;
        else               return 3'b100;
    endfunction

    task automatic clean();
        wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '0); wr(3'd4, '0);
        @(negedge clk); pins = '0;
        tick(4);
        wr(3'd3, 32'hFFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(4);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of all registers and requests.
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], rv);
            chk("R1 reset read", rv, 32'h0);
        end
        chk("R1 reset irq", {29'b0, irq_grp}, 32'h0);

        // Table walk: R2 R3 R8 R9.
        for (int i = 0; i < 8; i++) begin
            logic [10:0] v;
            int line, port, tgt, alt;
            logic up;
            string tag;
            v = VEC[i];
            line = int'(v[10:7]); port = int'(v[6:5]); up = v[2];
            tgt = port*16 + line;
            alt = ((port + 1) % 4)*16 + line;
            if (v[1])                tag = "R8 vector";
            else if (v[4] && v[3])   tag = "R3 vector";
            else if (v[3])           tag = "R3 vector";
            else                     tag = "R2 vector";
            @(negedge clk); pins = '0; pins[tgt] = ~up;
            wr(3'd0, 32'(1) << line);
            wr(3'd1, v[4] ? (32'(1) << line) : 32'h0);
            wr(3'd2, v[3] ? (32'(1) << line) : 32'h0);
            wr(3'd4, 32'(port) << (2*line));
            tick(5);
            wr(3'd3, 32'hFFFF);
            setpin(v[1] ? alt : tgt, up);
            tick(4);
            rd(3'd3, rv);
            chk(tag, rv, v[0] ? (32'(1) << line) : 32'h0);
            chk("R9 vector group", {29'b0, irq_grp}, v[0] ? {29'b0, grp_bit(line)} : 32'h0);
            clean();
        end

        // R10: latency of exactly three rising edges.
        wr(3'd0, 32'h10); wr(3'd1, 32'h10);
        tick(4);
        setpin(4, 1'b1);
        tick(2);
        rd(3'd3, rv);
        chk("R10 not yet after two edges", rv, 32'h0);
        tick(1);
        rd(3'd3, rv);
        chk("R10 pending after three edges", rv, 32'h10);

        // R5: sticky through pin activity; write 0 ignored; write 1 clears.
        setpin(4, 1'b0);
        tick(5);
        rd(3'd3, rv);
        chk("R5 sticky after pin drop", rv, 32'h10);
        wr(3'd3, 32'h0);
        rd(3'd3, rv);
        chk("R5 write zero ignored", rv, 32'h10);
        wr(3'd3, 32'h10);
        rd(3'd3, rv);
        chk("R5 write one clears", rv, 32'h0);
        chk("R5 irq dropped", {29'b0, irq_grp}, 32'h0);

        // R6: clear and a new edge in the same cycle.
        setpin(4, 1'b1);
        tick(2);
        wr(3'd3, 32'h10);
        rd(3'd3, rv);
        chk("R6 edge beats clear", rv, 32'h10);

        // R7: status masking by enable.
        wr(3'd0, 32'h0);
        rd(3'd3, rv);
        chk("R7 hidden when disabled", rv, 32'h0);
        chk("R7 irq low when disabled", {29'b0, irq_grp}, 32'h0);
        wr(3'd0, 32'h10);
        rd(3'd3, rv);
        chk("R7 shown again", rv, 32'h10);
        chk("R7 irq back", {29'b0, irq_grp}, 32'h4);
        clean();

        // R4: edges on a disabled line are not latched.
        wr(3'd1, 32'h40);
        tick(4);
        setpin(6, 1'b1);
        tick(5);
        wr(3'd0, 32'h40);
        rd(3'd3, rv);
        chk("R4 no latch while disabled", rv, 32'h0);
        chk("R4 irq low", {29'b0, irq_grp}, 32'h0);
        clean();

        // R9: two groups pending together, then one cleared.
        wr(3'd0, 32'h9); wr(3'd1, 32'h9);
        tick(4);
        @(negedge clk); pins[0] = 1'b1; pins[3] = 1'b1;
        tick(4);
        chk("R9 two groups", {29'b0, irq_grp}, 32'h3);
        wr(3'd3, 32'h1);
        chk("R9 group0 cleared", {29'b0, irq_grp}, 32'h2);
        clean();

        // R8: source register read-back and routing of port 3.
        wr(3'd4, 32'hC0000000);
        rd(3'd4, rv);
        chk("R8 select readback", rv, 32'hC0000000);
        wr(3'd0, 32'h8000); wr(3'd1, 32'h8000);
        tick(4);
        setpin(15, 1'b1);
        tick(4);
        rd(3'd3, rv);
        chk("R8 port0 pin ignored", rv, 32'h0);
        setpin(63, 1'b1);
        tick(4);
        rd(3'd3, rv);
        chk("R8 port3 pin routed", rv, 32'h8000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule